// File: doc/BRIEF.md
# Calendar Time Counter with Seconds Prescaler

This block keeps the calendar date and the time of day from a slow reference clock. A programmable prescaler divides the clock into a one-cycle seconds pulse. Each pulse advances a packed time word that holds hour, minute, second, day of week and week of month. At midnight the pulse also advances a packed date word that holds the full year, the month and the day of the month. The advance follows month lengths and the Gregorian leap-year rule.

Software uses one write port to load the divider/trim word, the date word or the time word. All three words are always visible on output ports. The seconds pulse and the packed words are meant to feed a neighbouring alarm comparator, so their field positions are fixed. The trim half of the divider word is only stored.

Top module: `cal_clock_core`

## Requirements
- R1: After reset the date word reads 0x000FA021 (year 2000, month 1, day 1). The time word reads 0x00120000 (week 1, weekday 1, 00:00:00). The divider/trim word reads 0x00007FFF.
- R2: With divide value D = divtrim_word[15:0], sec_tick is high for exactly one cycle in every D+1 cycles. D = 0 gives a pulse on every cycle, and D = 32767 on a 32.768 kHz clock gives one pulse per second.
- R3: wr_sel selects the register written when wr_en is high: 0 = divider/trim, 1 = date, 2 = time, 3 = nothing. A divider/trim write stores all 32 bits, and the trim half (bits 31:16) has no effect on the pulse. Any write with wr_sel 0, 1 or 2 restarts the prescaler, so the next pulse comes in the (D+1)-th cycle after the write cycle.
- R4: Date word layout: year in bits 20:9 (full year, not an offset), month in bits 8:5 (1 to 12), day in bits 4:0. Bits 31:21 read as zero, even when the written data has them set.
- R5: Time word layout: week of month in bits 22:20, day of week in bits 19:17 (1 to 7), hour in bits 16:12, minute in bits 11:6 and second in bits 5:0. Bits 31:23 read as zero. A time write shows up unchanged, apart from bits 31:23, on the cycle after the write.
- R6: On each pulse the second advances. Second 59 wraps to 0 and advances the minute. Minute 59 wraps to 0 and advances the hour. Hour 23 wraps to 0 and marks midnight.
- R7: At midnight the day advances. After the last day of the month it goes back to 1 and the month advances. February has 29 days when the year is divisible by 4, unless the year is divisible by 100 but not by 400. April, June, September and November have 30 days. All other months have 31.
- R8: Month 12 wraps to 1 and advances the year. The date word changes only at midnight or on a date write.
- R9: At midnight the day of week advances, with 7 wrapping to 1.
- R10: The week of month is (day + 6) / 7, using integer division. It is recomputed whenever the day changes, either by a midnight advance or by a date write. A date write updates this field of the time word in the same cycle.
- R11: A write cycle with wr_sel 0, 1 or 2 produces no pulse and no advance, even if the prescaler was due to wrap. A write with wr_sel 3 changes no register and does not disturb the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, nominally 32.768 kHz |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target register of the write |
| wr_data | input | 32 | Write data |
| sec_tick | output | 1 | One-cycle seconds pulse |
| date_word | output | 32 | Packed year/month/day |
| time_word | output | 32 | Packed week/weekday/hour/minute/second |
| divtrim_word | output | 32 | Divide value (15:0) and stored trim (31:16) |

## Verification
The hardest situations to reach are the rare carries: a midnight that crosses a month end, a year end, or a February in a leap or century year. At the real divide value these take days of simulated time. The stimulus sets the divide value to zero so that every cycle is a pulse. It then loads 23:59:59 together with a date just before the boundary, so one cycle reaches the carry. A loop repeats that load across more than two years of consecutive days. Writes that land exactly on a due pulse also get dedicated stimulus, because with a zero divider every write collides with a wrap.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int REG_W  = 32;
  localparam int DIV_W  = 16;
  localparam int TRIM_W = 16;
  localparam int YEAR_W = 12;
  localparam int MON_W  = 4;
  localparam int DAY_W  = 5;
  localparam int HOUR_W = 5;
  localparam int MIN_W  = 6;
  localparam int SEC_W  = 6;
  localparam int DOW_W  = 3;
  localparam int WOM_W  = 3;

  typedef enum logic [1:0] {
    SEL_DIVTRIM = 2'd0,
    SEL_DATE    = 2'd1,
    SEL_TIME    = 2'd2,
    SEL_NONE    = 2'd3
  } wr_sel_e;

  // Field order matches the packed date layout (year high, day low).
  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  month;
    logic [DAY_W-1:0]  day;
  } cal_date_t;

  // Field order matches the packed time layout (week high, second low).
  typedef struct packed {
    logic [WOM_W-1:0]  wom;
    logic [DOW_W-1:0]  dow;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  minute;
    logic [SEC_W-1:0]  second;
  } cal_time_t;

  localparam int DATE_W = $bits(cal_date_t);
  localparam int TIME_W = $bits(cal_time_t);

  function automatic logic is_leap(input logic [YEAR_W-1:0] y);
    logic by4, by100, by400;
    by4   = (y[1:0] == 2'b00);
    by100 = ((y % YEAR_W'(100)) == '0);
    by400 = ((y % YEAR_W'(400)) == '0);
    return by4 && (!by100 || by400);
  endfunction

  function automatic logic [DAY_W-1:0] month_days(input logic [YEAR_W-1:0] y,
                                                  input logic [MON_W-1:0]  m);
    logic [DAY_W-1:0] n;
    case (m)
      MON_W'(2):                          n = is_leap(y) ? DAY_W'(29) : DAY_W'(28);
      MON_W'(4), MON_W'(6),
      MON_W'(9), MON_W'(11):              n = DAY_W'(30);
      default:                            n = DAY_W'(31);
    endcase
    return n;
  endfunction

  function automatic logic [WOM_W-1:0] week_of_month(input logic [DAY_W-1:0] d);
    logic [DAY_W:0] s;
    s = {1'b0, d} + (DAY_W+1)'(6);
    return WOM_W'(s / (DAY_W+1)'(7));
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler
  import cal_pkg::*;
#(
  parameter int CNT_W = DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q;

  // >= also covers a limit lowered below the running count.
  assign wrap = (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || wrap)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/cal_tod.sv
module cal_tod
  import cal_pkg::*;
#(
  parameter cal_time_t RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  cal_time_t        load_val,
  input  logic             wom_set,
  input  logic [WOM_W-1:0] wom_val,
  output cal_time_t        tod_q,
  output logic             day_carry
);

  localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(59);
  localparam logic [MIN_W-1:0]  MIN_LAST  = MIN_W'(59);
  localparam logic [HOUR_W-1:0] HOUR_LAST = HOUR_W'(23);
  localparam logic [DOW_W-1:0]  DOW_LAST  = DOW_W'(7);
  localparam logic [DOW_W-1:0]  DOW_FIRST = DOW_W'(1);

  logic sec_wrap, min_wrap, hour_wrap;
  logic min_step, hour_step;
  cal_time_t tod_d;

  assign sec_wrap  = (tod_q.second >= SEC_LAST);
  assign min_wrap  = (tod_q.minute >= MIN_LAST);
  assign hour_wrap = (tod_q.hour   >= HOUR_LAST);
  assign min_step  = step & sec_wrap;
  assign hour_step = min_step & min_wrap;
  assign day_carry = hour_step & hour_wrap;

  always_comb begin
    tod_d = tod_q;
    if (load) begin
      tod_d = load_val;
    end else if (step) begin
      tod_d.second = sec_wrap ? '0 : tod_q.second + SEC_W'(1);
      if (min_step)
        tod_d.minute = min_wrap ? '0 : tod_q.minute + MIN_W'(1);
      if (hour_step)
        tod_d.hour = hour_wrap ? '0 : tod_q.hour + HOUR_W'(1);
      if (day_carry)
        tod_d.dow = (tod_q.dow >= DOW_LAST) ? DOW_FIRST : tod_q.dow + DOW_W'(1);
    end
    if (wom_set)
      tod_d.wom = wom_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tod_q <= RST_VAL;
    else        tod_q <= tod_d;
  end

endmodule

// File: rtl/cal_date.sv
module cal_date
  import cal_pkg::*;
#(
  parameter cal_date_t RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  cal_date_t        load_val,
  output cal_date_t        date_q,
  output logic [DAY_W-1:0] day_next
);

  localparam logic [MON_W-1:0] MON_LAST = MON_W'(12);

  logic [DAY_W-1:0] month_len;
  logic             end_of_month, end_of_year;
  cal_date_t        date_d;

  assign month_len    = month_days(date_q.year, date_q.month);
  assign end_of_month = (date_q.day >= month_len);
  assign end_of_year  = (date_q.month >= MON_LAST);
  assign day_next     = end_of_month ? DAY_W'(1) : date_q.day + DAY_W'(1);

  always_comb begin
    date_d = date_q;
    if (load) begin
      date_d = load_val;
    end else if (step) begin
      date_d.day = day_next;
      if (end_of_month) begin
        date_d.month = end_of_year ? MON_W'(1) : date_q.month + MON_W'(1);
        if (end_of_year)
          date_d.year = date_q.year + YEAR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) date_q <= RST_VAL;
    else        date_q <= date_d;
  end

endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core
  import cal_pkg::*;
#(
  parameter int unsigned RESET_YEAR   = 2000,
  parameter int unsigned RESET_MONTH  = 1,
  parameter int unsigned RESET_DAY    = 1,
  parameter int unsigned RESET_DOW    = 1,
  parameter int unsigned RESET_DIVIDE = 32767
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic             sec_tick,
  output logic [REG_W-1:0] date_word,
  output logic [REG_W-1:0] time_word,
  output logic [REG_W-1:0] divtrim_word
);

  localparam cal_date_t DATE_RST = '{
    year:  YEAR_W'(RESET_YEAR),
    month: MON_W'(RESET_MONTH),
    day:   DAY_W'(RESET_DAY)
  };
  localparam cal_time_t TIME_RST = '{
    wom:    week_of_month(DAY_W'(RESET_DAY)),
    dow:    DOW_W'(RESET_DOW),
    hour:   '0,
    minute: '0,
    second: '0
  };
  localparam logic [REG_W-1:0] DIVTRIM_RST = {{TRIM_W{1'b0}}, DIV_W'(RESET_DIVIDE)};

  wr_sel_e          sel;
  logic             load_div, load_date, load_time, any_load;
  logic             wrap_raw, day_carry;
  logic [REG_W-1:0] divtrim_q;
  cal_date_t        date_q, date_wr;
  cal_time_t        tod_q, time_wr;
  logic [DAY_W-1:0] day_next, wom_day;
  logic             wom_set;
  logic [WOM_W-1:0] wom_val;

  assign sel       = wr_sel_e'(wr_sel);
  assign load_div  = wr_en && (sel == SEL_DIVTRIM);
  assign load_date = wr_en && (sel == SEL_DATE);
  assign load_time = wr_en && (sel == SEL_TIME);
  assign any_load  = load_div | load_date | load_time;

  assign date_wr = cal_date_t'(wr_data[DATE_W-1:0]);
  assign time_wr = cal_time_t'(wr_data[TIME_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n)        divtrim_q <= DIVTRIM_RST;
    else if (load_div) divtrim_q <= wr_data;
  end

  cal_prescaler #(.CNT_W(DIV_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (any_load),
    .limit   (divtrim_q[DIV_W-1:0]),
    .wrap    (wrap_raw)
  );

  // A register write owns its cycle: the pending wrap is dropped.
  assign sec_tick = wrap_raw & ~any_load;

  cal_date #(.RST_VAL(DATE_RST)) u_date (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (day_carry),
    .load     (load_date),
    .load_val (date_wr),
    .date_q   (date_q),
    .day_next (day_next)
  );

  assign wom_set = load_date | day_carry;
  assign wom_day = load_date ? date_wr.day : day_next;
  assign wom_val = week_of_month(wom_day);

  cal_tod #(.RST_VAL(TIME_RST)) u_tod (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (sec_tick),
    .load      (load_time),
    .load_val  (time_wr),
    .wom_set   (wom_set),
    .wom_val   (wom_val),
    .tod_q     (tod_q),
    .day_carry (day_carry)
  );

  assign date_word    = REG_W'(date_q);
  assign time_word    = REG_W'(tod_q);
  assign divtrim_word = divtrim_q;

endmodule

// File: rtl/cal_clock_core_chk.sv
module cal_clock_core_chk
  import cal_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [REG_W-1:0] wr_data,
  input logic             sec_tick,
  input logic [REG_W-1:0] date_word,
  input logic [REG_W-1:0] time_word,
  input logic [REG_W-1:0] divtrim_word,
  input logic             day_carry
);

  logic hit;
  assign hit = wr_en && (wr_sel != 2'd3);

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && divtrim_word[15:0] != 16'd0) |=> !sec_tick);

  p_write_masks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !sec_tick);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !hit) |=> ($stable(date_word) && $stable(time_word) && $stable(divtrim_word)));

  p_unused_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (date_word[31:21] == 11'd0) && (time_word[31:23] == 9'd0));

  p_time_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> (time_word == {9'd0, $past(wr_data[22:0])}));

  p_sec_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && time_word[5:0] < 6'd59) |=> (time_word[5:0] == $past(time_word[5:0]) + 6'd1));

  p_date_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !day_carry) |=> $stable(date_word));

  p_dow_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && time_word[19:17] == 3'd7) |=> (time_word[19:17] == 3'd1));

  p_midnight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |=> (time_word[16:0] == 17'd0));

endmodule

bind cal_clock_core cal_clock_core_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .wr_data      (wr_data),
  .sec_tick     (sec_tick),
  .date_word    (date_word),
  .time_word    (time_word),
  .divtrim_word (divtrim_word),
  .day_carry    (day_carry)
);

// File: tb/cal_clock_core_tb_top.sv
`timescale 1ns/1ps
module cal_clock_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic        sec_tick;
  logic [31:0] date_word, time_word, divtrim_word;

  always #4 clk = ~clk;

  cal_clock_core dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_tick(sec_tick), .date_word(date_word), .time_word(time_word),
    .divtrim_word(divtrim_word)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  string cur_req = "R1";
  int obs_ticks = 0;

  // Reference state, plain integers.
  int m_year = 2000, m_mon = 1, m_day = 1, m_dow = 1, m_wom = 1;
  int m_hh = 0, m_mm = 0, m_ss = 0;
  int m_div = 32767, m_cnt = 0;
  logic [31:0] m_divtrim = 32'h0000_7FFF;

  function automatic logic [31:0] dword(int y, int m, int d);
    return (32'(y) << 9) | (32'(m) << 5) | 32'(d);
  endfunction

  function automatic logic [31:0] tword(int w, int dw, int h, int mi, int s);
    return (32'(w) << 20) | (32'(dw) << 17) | (32'(h) << 12) | (32'(mi) << 6) | 32'(s);
  endfunction

  function automatic int mlen(int y, int m);
    int tbl[12] = '{31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31};
    bit leap = ((y % 400) == 0) || (((y % 4) == 0) && ((y % 100) != 0));
    if (m == 2 && leap) return 29;
    return tbl[m-1];
  endfunction

  task automatic model_advance();
    m_ss++;
    if (m_ss >= 60) begin
      m_ss = 0; m_mm++;
      if (m_mm >= 60) begin
        m_mm = 0; m_hh++;
        if (m_hh >= 24) begin
          m_hh = 0;
          m_dow = (m_dow >= 7) ? 1 : m_dow + 1;
          m_day++;
          if (m_day > mlen(m_year, m_mon)) begin
            m_day = 1; m_mon++;
            if (m_mon > 12) begin m_mon = 1; m_year = (m_year + 1) % 4096; end
          end
          m_wom = (m_day + 6) / 7;
        end
      end
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Entered just after a negedge; leaves just after the next negedge.
  task automatic cycle(bit we, logic [1:0] sel, logic [31:0] data);
    bit hit, exp_tick;
    logic [31:0] ed, et;
    wr_en = we; wr_sel = sel; wr_data = data;
    #1;
    hit = we && (sel != 2'd3);
    exp_tick = (m_cnt >= m_div) && !hit;
    ed = dword(m_year, m_mon, m_day);
    et = tword(m_wom, m_dow, m_hh, m_mm, m_ss);
    vectors++;
    if (sec_tick !== exp_tick || date_word !== ed || time_word !== et || divtrim_word !== m_divtrim) begin
      miscompares++;
      $display("FAIL %s cycle tick %0b/%0b date 0x%08h/0x%08h time 0x%08h/0x%08h div 0x%08h/0x%08h (actual/expected)",
               cur_req, sec_tick, exp_tick, date_word, ed, time_word, et, divtrim_word, m_divtrim);
    end
    if (sec_tick === 1'b1) obs_ticks++;
    @(posedge clk);
    if (hit) begin
      m_cnt = 0;
      case (sel)
        2'd0: begin m_divtrim = data; m_div = int'(data[15:0]); end
        2'd1: begin
          m_year = int'(data[20:9]); m_mon = int'(data[8:5]); m_day = int'(data[4:0]);
          m_wom = (m_day + 6) / 7;
        end
        default: begin
          m_wom = int'(data[22:20]); m_dow = int'(data[19:17]); m_hh = int'(data[16:12]);
          m_mm = int'(data[11:6]); m_ss = int'(data[5:0]);
        end
      endcase
    end else if (exp_tick) begin
      m_cnt = 0;
      model_advance();
    end else begin
      m_cnt++;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 2'd0, 32'd0);
  endtask

  task automatic set_point(int y, int mo, int d, int dw, int h, int mi, int s);
    cycle(1'b1, 2'd1, dword(y, mo, d));
    cycle(1'b1, 2'd2, tword((d + 6) / 7, dw, h, mi, s));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset values
    chk("R1", date_word, 32'h000F_A021);
    chk("R1", time_word, 32'h0012_0000);
    chk("R1", divtrim_word, 32'h0000_7FFF);
    cur_req = "R2";
    idle(6);
    chk("R2", 32'(obs_ticks), 32'd0);

    // R3 divider/trim write, trim ignored, phase restart
    cur_req = "R3";
    cycle(1'b1, 2'd0, 32'hABCD_0003);
    chk("R3", divtrim_word, 32'hABCD_0003);
    obs_ticks = 0;
    cur_req = "R2";
    idle(12);
    chk("R2", 32'(obs_ticks), 32'd3);
    chk("R6", time_word, tword(1, 1, 0, 0, 3));

    // Fast mode: pulse every cycle
    cur_req = "R3";
    cycle(1'b1, 2'd0, 32'h0000_0000);
    cur_req = "R6";
    set_point(2024, 5, 3, 2, 0, 59, 58);
    idle(2);
    chk("R6", time_word, tword(1, 2, 1, 0, 0));

    // R7 leap February and R9 weekday wrap
    cur_req = "R7";
    set_point(2024, 2, 28, 7, 23, 59, 59);
    idle(1);
    chk("R7", date_word, dword(2024, 2, 29));
    chk("R9", time_word, tword(5, 1, 0, 0, 0));
    set_point(2024, 2, 29, 1, 23, 59, 59);
    idle(1);
    chk("R7", date_word, dword(2024, 3, 1));
    set_point(2023, 2, 28, 3, 23, 59, 59);
    idle(1);
    chk("R7", date_word, dword(2023, 3, 1));
    set_point(2100, 2, 28, 3, 23, 59, 59);
    idle(1);
    chk("R7", date_word, dword(2100, 3, 1));
    set_point(2000, 2, 28, 3, 23, 59, 59);
    idle(1);
    chk("R7", date_word, dword(2000, 2, 29));
    set_point(2024, 4, 30, 3, 23, 59, 59);
    idle(1);
    chk("R7", date_word, dword(2024, 5, 1));

    // R8 year wrap
    cur_req = "R8";
    set_point(2023, 12, 31, 6, 23, 59, 59);
    idle(1);
    chk("R8", date_word, dword(2024, 1, 1));
    chk("R8", time_word, tword(1, 7, 0, 0, 0));

    // R10 week of month
    cur_req = "R10";
    set_point(2024, 6, 7, 5, 23, 59, 59);
    idle(1);
    chk("R10", time_word, tword(2, 6, 0, 0, 0));
    cycle(1'b1, 2'd1, dword(2024, 6, 15));
    chk("R10", time_word[22:20], 32'd3);

    // R4 / R5 unused upper bits
    cur_req = "R4";
    cycle(1'b1, 2'd1, 32'hFFE0_0000 | dword(2031, 7, 22));
    chk("R4", date_word, dword(2031, 7, 22));
    cur_req = "R5";
    cycle(1'b1, 2'd2, 32'hFF80_0000 | tword(4, 3, 12, 34, 56));
    chk("R5", time_word, tword(4, 3, 12, 34, 56));

    // R11 write collides with due wrap; wr_sel 3 ignored
    cur_req = "R11";
    cycle(1'b1, 2'd2, tword(1, 1, 10, 0, 0));
    chk("R11", time_word, tword(1, 1, 10, 0, 0));
    cycle(1'b1, 2'd3, 32'hFFFF_FFFF);
    chk("R11", time_word, tword(1, 1, 10, 0, 1));
    chk("R11", divtrim_word, 32'h0000_0000);
    chk("R11", date_word, dword(2031, 7, 22));

    // R7 long walk over consecutive days
    cur_req = "R7";
    set_point(2023, 1, 1, 1, 23, 59, 59);
    for (int k = 0; k < 800; k++) begin
      idle(1);
      cycle(1'b1, 2'd2, tword(m_wom, m_dow, 23, 59, 59));
    end
    idle(1);
    chk("R7", date_word, dword(2025, 3, 12));
    chk("R9", time_word, tword(2, 4, 0, 0, 0));

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired actual running expected done");
      summary();
      $finish;
    end
  end

endmodule